// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a decoded operand addressing byte into a memory address. The byte carries a two-bit mode, a three-bit register field and a three-bit register/memory selector. Alongside it the block receives the operand-size bit, up to two displacement bytes, the current base and index register values (BX, BP, SI, DI) and the four segment register values. It computes the 16-bit effective offset and the 20-bit physical address from these inputs. The physical address is the segment moved up by four bit positions plus the offset.

The block also reports how many displacement bytes the encoding consumes. It flags when the operand is a register rather than memory, and in that case it returns the register index for both the selector field and the register field. The index is the size bit concatenated with the three-bit code. An optional override input replaces the default segment choice. All results are computed combinationally and captured in one output register stage. A result therefore appears on the cycle after the input is presented with `in_valid` high.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it until the first valid input is captured, `out_valid`, `is_reg`, both index outputs, `disp_bytes`, `seg_sel`, `ea_offset` and `phys_addr` are all zero.
- R2: Each result appears exactly one clock after the input is sampled with `in_valid` high, and `out_valid` is high for that one cycle only.
- R3: Mode 11 (addressing byte bits 7:6) marks a register operand. In that case `is_reg`=1, `rm_reg_idx`={w, byte bits 2:0}, `disp_bytes`=0, and `ea_offset` and `phys_addr` are 0.
- R4: Mode 00 with a selector other than 110 uses no displacement. `disp_bytes`=0, and the displacement inputs have no effect on the offset.
- R5: Mode 00 with selector 110 is a direct address. The offset is {disp_hi, disp_lo}, no register is added, `disp_bytes`=2, and the default segment is DS.
- R6: Mode 01 adds `disp_lo` sign-extended to 16 bits, with `disp_bytes`=1.
- R7: Mode 10 adds the 16-bit {disp_hi, disp_lo}, with `disp_bytes`=2. In modes 01 and 10, selector 110 means BP plus displacement.
- R8: The selector (bits 2:0) chooses the registers to sum. The codes are 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 110 BP and 111 BX.
- R9: The offset sum wraps modulo 2^16.
- R10: `phys_addr` = segment*16 + `ea_offset`, taken modulo 2^20.
- R11: `seg_sel` is coded 00 ES, 01 CS, 10 SS, 11 DS. Without an override it is SS for every form that adds BP, and DS otherwise.
- R12: When `ovr_en`=1, `seg_sel` equals `ovr_sel`, and that segment's value forms the physical address.
- R13: `fld_reg_idx` = {w, byte bits 5:3} for every captured input.
- R14: While `in_valid` is low, every data output holds its last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture the inputs on this edge |
| modrm | input | 8 | Addressing byte: mode 7:6, register field 5:3, selector 2:0 |
| wide | input | 1 | Operand size bit (1 = word) |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte |
| bx_val | input | 16 | BX register value |
| bp_val | input | 16 | BP register value |
| si_val | input | 16 | SI register value |
| di_val | input | 16 | DI register value |
| es_val | input | 16 | ES segment value |
| cs_val | input | 16 | CS segment value |
| ss_val | input | 16 | SS segment value |
| ds_val | input | 16 | DS segment value |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code (00 ES, 01 CS, 10 SS, 11 DS) |
| out_valid | output | 1 | Result registered this cycle |
| is_reg | output | 1 | Operand is a register |
| rm_reg_idx | output | 4 | {w, selector} register index |
| fld_reg_idx | output | 4 | {w, register field} index |
| disp_bytes | output | 2 | Displacement bytes consumed (0, 1 or 2) |
| seg_sel | output | 2 | Segment used |
| ea_offset | output | 16 | Effective offset |
| phys_addr | output | 20 | Physical address |

## Verification
The checker assumes that every input is a known value whenever `in_valid` is high. It also assumes that the register and segment values are those of the same cycle as the addressing byte, because its physical-address property recomputes the sum from segment values captured on the same edge. The bench meets these assumptions by driving every input to a defined value from time zero. It changes inputs only on falling edges, and it raises `in_valid` for one cycle per operand. Junk displacement bytes are driven on purpose in the encodings that must ignore them.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int unsigned EAG_BYTE_W    = 8;
    localparam int unsigned EAG_OFS_W     = 2 * EAG_BYTE_W;
    localparam int unsigned EAG_SEG_SHIFT = 4;
    localparam int unsigned EAG_PHYS_W    = EAG_OFS_W + EAG_SEG_SHIFT;
    localparam int unsigned EAG_FLD_W     = 3;
    localparam int unsigned EAG_RIDX_W    = EAG_FLD_W + 1;

    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_D8     = 2'b01;
    localparam logic [1:0] MODE_D16    = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;
    localparam logic [EAG_FLD_W-1:0] SEL_BP_OR_DIRECT = 3'b110;

    typedef enum logic [1:0] {
        SEG_ES = 2'b00,
        SEG_CS = 2'b01,
        SEG_SS = 2'b10,
        SEG_DS = 2'b11
    } seg_code_e;

    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_BX   = 2'd1,
        BASE_BP   = 2'd2
    } base_sel_e;

    typedef enum logic [1:0] {
        IDX_NONE = 2'd0,
        IDX_SI   = 2'd1,
        IDX_DI   = 2'd2
    } idx_sel_e;

    typedef enum logic [1:0] {
        DSP_NONE = 2'd0,
        DSP_S8   = 2'd1,
        DSP_W16  = 2'd2
    } disp_kind_e;

    typedef struct packed {
        logic                    valid;
        logic                    is_reg;
        logic [EAG_RIDX_W-1:0]   rm_idx;
        logic [EAG_RIDX_W-1:0]   fld_idx;
        logic [1:0]              disp_bytes;
        seg_code_e               seg;
        logic [EAG_OFS_W-1:0]    offset;
        logic [EAG_PHYS_W-1:0]   phys;
    } eag_out_t;

endpackage

// File: rtl/eag_modrm_decode.sv
module eag_modrm_decode
    import eag_pkg::*;
(
    input  logic [1:0]           mode,
    input  logic [EAG_FLD_W-1:0] sel,
    output base_sel_e            base_sel,
    output idx_sel_e             idx_sel,
    output disp_kind_e           disp_kind,
    output logic [1:0]           disp_bytes,
    output logic                 is_reg,
    output logic                 stack_rel
);

    always_comb begin
        base_sel   = BASE_NONE;
        idx_sel    = IDX_NONE;
        disp_kind  = DSP_NONE;
        disp_bytes = 2'd0;
        is_reg     = 1'b0;

        // selector table: base/index pair
        case (sel)
            3'b000: begin base_sel = BASE_BX;   idx_sel = IDX_SI;   end
            3'b001: begin base_sel = BASE_BX;   idx_sel = IDX_DI;   end
            3'b010: begin base_sel = BASE_BP;   idx_sel = IDX_SI;   end
            3'b011: begin base_sel = BASE_BP;   idx_sel = IDX_DI;   end
            3'b100: begin base_sel = BASE_NONE; idx_sel = IDX_SI;   end
            3'b101: begin base_sel = BASE_NONE; idx_sel = IDX_DI;   end
            3'b110: begin base_sel = BASE_BP;   idx_sel = IDX_NONE; end
            default: begin base_sel = BASE_BX;  idx_sel = IDX_NONE; end
        endcase

        case (mode)
            MODE_NODISP: begin
                if (sel == SEL_BP_OR_DIRECT) begin
                    base_sel   = BASE_NONE;
                    disp_kind  = DSP_W16;
                    disp_bytes = 2'd2;
                end
            end
            MODE_D8: begin
                disp_kind  = DSP_S8;
                disp_bytes = 2'd1;
            end
            MODE_D16: begin
                disp_kind  = DSP_W16;
                disp_bytes = 2'd2;
            end
            default: begin
                base_sel = BASE_NONE;
                idx_sel  = IDX_NONE;
                is_reg   = 1'b1;
            end
        endcase

        stack_rel = (base_sel == BASE_BP);
    end

endmodule

// File: rtl/eag_offset_calc.sv
module eag_offset_calc
    import eag_pkg::*;
#(
    parameter int unsigned OFS_W  = EAG_OFS_W,
    parameter int unsigned BYTE_W = EAG_BYTE_W
) (
    input  base_sel_e          base_sel,
    input  idx_sel_e           idx_sel,
    input  disp_kind_e         disp_kind,
    input  logic [OFS_W-1:0]   bx_val,
    input  logic [OFS_W-1:0]   bp_val,
    input  logic [OFS_W-1:0]   si_val,
    input  logic [OFS_W-1:0]   di_val,
    input  logic [BYTE_W-1:0]  disp_lo,
    input  logic [BYTE_W-1:0]  disp_hi,
    output logic [OFS_W-1:0]   offset
);

    localparam int unsigned EXT_W = OFS_W - BYTE_W;

    logic [OFS_W-1:0] base_term;
    logic [OFS_W-1:0] idx_term;
    logic [OFS_W-1:0] disp_term;
    logic [OFS_W-1:0] disp_s8;
    logic [OFS_W-1:0] disp_w16;

    generate
        if (OFS_W > 2 * BYTE_W) begin : g_wide_ofs
            assign disp_w16 = {{(OFS_W - 2 * BYTE_W){1'b0}}, disp_hi, disp_lo};
        end else begin : g_exact_ofs
            assign disp_w16 = OFS_W'({disp_hi, disp_lo});
        end
    endgenerate

    assign disp_s8 = {{EXT_W{disp_lo[BYTE_W-1]}}, disp_lo};

    always_comb begin
        case (base_sel)
            BASE_BX: base_term = bx_val;
            BASE_BP: base_term = bp_val;
            default: base_term = '0;
        endcase
        case (idx_sel)
            IDX_SI:  idx_term = si_val;
            IDX_DI:  idx_term = di_val;
            default: idx_term = '0;
        endcase
        case (disp_kind)
            DSP_S8:  disp_term = disp_s8;
            DSP_W16: disp_term = disp_w16;
            default: disp_term = '0;
        endcase
        // truncating sum: wraps modulo 2^OFS_W
        offset = base_term + idx_term + disp_term;
    end

endmodule

// File: rtl/eag_phys_calc.sv
module eag_phys_calc
    import eag_pkg::*;
#(
    parameter int unsigned OFS_W     = EAG_OFS_W,
    parameter int unsigned SEG_SHIFT = EAG_SEG_SHIFT,
    localparam int unsigned PHYS_W   = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0]  seg_val,
    input  logic [OFS_W-1:0]  offset,
    output logic [PHYS_W-1:0] phys
);

    generate
        if (SEG_SHIFT == 0) begin : g_flat
            assign phys = seg_val + offset;
        end else begin : g_shifted
            logic [PHYS_W-1:0] seg_ext;
            logic [PHYS_W-1:0] ofs_ext;
            assign seg_ext = {seg_val, {SEG_SHIFT{1'b0}}};
            assign ofs_ext = {{SEG_SHIFT{1'b0}}, offset};
            // truncating sum: wraps modulo 2^PHYS_W
            assign phys    = seg_ext + ofs_ext;
        end
    endgenerate

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import eag_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              modrm,
    input  logic                    wide,
    input  logic [EAG_BYTE_W-1:0]   disp_lo,
    input  logic [EAG_BYTE_W-1:0]   disp_hi,
    input  logic [EAG_OFS_W-1:0]    bx_val,
    input  logic [EAG_OFS_W-1:0]    bp_val,
    input  logic [EAG_OFS_W-1:0]    si_val,
    input  logic [EAG_OFS_W-1:0]    di_val,
    input  logic [EAG_OFS_W-1:0]    es_val,
    input  logic [EAG_OFS_W-1:0]    cs_val,
    input  logic [EAG_OFS_W-1:0]    ss_val,
    input  logic [EAG_OFS_W-1:0]    ds_val,
    input  logic                    ovr_en,
    input  logic [1:0]              ovr_sel,
    output logic                    out_valid,
    output logic                    is_reg,
    output logic [EAG_RIDX_W-1:0]   rm_reg_idx,
    output logic [EAG_RIDX_W-1:0]   fld_reg_idx,
    output logic [1:0]              disp_bytes,
    output logic [1:0]              seg_sel,
    output logic [EAG_OFS_W-1:0]    ea_offset,
    output logic [EAG_PHYS_W-1:0]   phys_addr
);

    logic [1:0]           f_mode;
    logic [EAG_FLD_W-1:0] f_reg;
    logic [EAG_FLD_W-1:0] f_sel;

    assign f_mode = modrm[7:6];
    assign f_reg  = modrm[5:3];
    assign f_sel  = modrm[2:0];

    base_sel_e            dec_base;
    idx_sel_e             dec_idx;
    disp_kind_e           dec_disp;
    logic [1:0]           dec_nbytes;
    logic                 dec_is_reg;
    logic                 dec_stack;

    eag_modrm_decode u_decode (
        .mode       (f_mode),
        .sel        (f_sel),
        .base_sel   (dec_base),
        .idx_sel    (dec_idx),
        .disp_kind  (dec_disp),
        .disp_bytes (dec_nbytes),
        .is_reg     (dec_is_reg),
        .stack_rel  (dec_stack)
    );

    logic [EAG_OFS_W-1:0] ofs_c;

    eag_offset_calc #(
        .OFS_W  (EAG_OFS_W),
        .BYTE_W (EAG_BYTE_W)
    ) u_offset (
        .base_sel  (dec_base),
        .idx_sel   (dec_idx),
        .disp_kind (dec_disp),
        .bx_val    (bx_val),
        .bp_val    (bp_val),
        .si_val    (si_val),
        .di_val    (di_val),
        .disp_lo   (disp_lo),
        .disp_hi   (disp_hi),
        .offset    (ofs_c)
    );

    seg_code_e            seg_c;
    logic [EAG_OFS_W-1:0] seg_val_c;

    always_comb begin
        if (ovr_en) begin
            seg_c = seg_code_e'(ovr_sel);
        end else if (dec_stack) begin
            seg_c = SEG_SS;
        end else begin
            seg_c = SEG_DS;
        end
        case (seg_c)
            SEG_ES:  seg_val_c = es_val;
            SEG_CS:  seg_val_c = cs_val;
            SEG_SS:  seg_val_c = ss_val;
            default: seg_val_c = ds_val;
        endcase
    end

    logic [EAG_PHYS_W-1:0] phys_c;

    eag_phys_calc #(
        .OFS_W     (EAG_OFS_W),
        .SEG_SHIFT (EAG_SEG_SHIFT)
    ) u_phys (
        .seg_val (seg_val_c),
        .offset  (ofs_c),
        .phys    (phys_c)
    );

    eag_out_t res_d;
    eag_out_t res_q;

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.is_reg     = dec_is_reg;
            res_d.rm_idx     = {wide, f_sel};
            res_d.fld_idx    = {wide, f_reg};
            res_d.disp_bytes = dec_nbytes;
            res_d.seg        = seg_c;
            if (dec_is_reg) begin
                res_d.offset = '0;
                res_d.phys   = '0;
            end else begin
                res_d.offset = ofs_c;
                res_d.phys   = phys_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign is_reg      = res_q.is_reg;
    assign rm_reg_idx  = res_q.rm_idx;
    assign fld_reg_idx = res_q.fld_idx;
    assign disp_bytes  = res_q.disp_bytes;
    assign seg_sel     = res_q.seg;
    assign ea_offset   = res_q.offset;
    assign phys_addr   = res_q.phys;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
    import eag_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [7:0]            modrm,
    input logic                  wide,
    input logic [EAG_BYTE_W-1:0] disp_lo,
    input logic [EAG_BYTE_W-1:0] disp_hi,
    input logic [EAG_OFS_W-1:0]  es_val,
    input logic [EAG_OFS_W-1:0]  cs_val,
    input logic [EAG_OFS_W-1:0]  ss_val,
    input logic [EAG_OFS_W-1:0]  ds_val,
    input logic                  ovr_en,
    input logic [1:0]            ovr_sel,
    input logic                  out_valid,
    input logic                  is_reg,
    input logic [EAG_RIDX_W-1:0] fld_reg_idx,
    input logic [1:0]            disp_bytes,
    input logic [1:0]            seg_sel,
    input logic [EAG_OFS_W-1:0]  ea_offset,
    input logic [EAG_PHYS_W-1:0] phys_addr
);

    logic [EAG_OFS_W-1:0]  es_h, cs_h, ss_h, ds_h;
    logic [EAG_OFS_W-1:0]  seg_pick;
    logic [EAG_PHYS_W-1:0] phys_ref;

    always_ff @(posedge clk) begin
        if (in_valid) begin
            es_h <= es_val;
            cs_h <= cs_val;
            ss_h <= ss_val;
            ds_h <= ds_val;
        end
    end

    always_comb begin
        case (seg_sel)
            2'b00:   seg_pick = es_h;
            2'b01:   seg_pick = cs_h;
            2'b10:   seg_pick = ss_h;
            default: seg_pick = ds_h;
        endcase
        phys_ref = {seg_pick, {EAG_SEG_SHIFT{1'b0}}} + {{EAG_SEG_SHIFT{1'b0}}, ea_offset};
    end

    // R2
    latency_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    latency_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    reg_operand_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_reg) |-> (ea_offset == '0 && phys_addr == '0 && disp_bytes == 2'd0));

    // R5
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110 && !ovr_en)
        |=> (ea_offset == $past({disp_hi, disp_lo}) && disp_bytes == 2'd2 && seg_sel == 2'b11));

    // R10
    phys_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_reg) |-> (phys_addr == phys_ref));

    // R12
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovr_en) |=> (seg_sel == $past(ovr_sel)));

    // R13
    fld_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (fld_reg_idx == $past({wide, modrm[5:3]})));

    // R14
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(ea_offset) && $stable(phys_addr) && $stable(seg_sel)));

endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .modrm       (modrm),
    .wide        (wide),
    .disp_lo     (disp_lo),
    .disp_hi     (disp_hi),
    .es_val      (es_val),
    .cs_val      (cs_val),
    .ss_val      (ss_val),
    .ds_val      (ds_val),
    .ovr_en      (ovr_en),
    .ovr_sel     (ovr_sel),
    .out_valid   (out_valid),
    .is_reg      (is_reg),
    .fld_reg_idx (fld_reg_idx),
    .disp_bytes  (disp_bytes),
    .seg_sel     (seg_sel),
    .ea_offset   (ea_offset),
    .phys_addr   (phys_addr)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  modrm = 8'h00;
    logic        wide = 1'b0;
    logic [7:0]  disp_lo = 8'h00;
    logic [7:0]  disp_hi = 8'h00;
    logic [15:0] bx_val = 16'h1000;
    logic [15:0] bp_val = 16'h2000;
    logic [15:0] si_val = 16'h0030;
    logic [15:0] di_val = 16'h0004;
    logic [15:0] es_val = 16'hA000;
    logic [15:0] cs_val = 16'hFFFF;
    logic [15:0] ss_val = 16'h5000;
    logic [15:0] ds_val = 16'h1234;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = 2'b00;

    logic        out_valid;
    logic        is_reg;
    logic [3:0]  rm_reg_idx;
    logic [3:0]  fld_reg_idx;
    logic [1:0]  disp_bytes;
    logic [1:0]  seg_sel;
    logic [15:0] ea_offset;
    logic [19:0] phys_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm(modrm), .wide(wide),
        .disp_lo(disp_lo), .disp_hi(disp_hi),
        .bx_val(bx_val), .bp_val(bp_val), .si_val(si_val), .di_val(di_val),
        .es_val(es_val), .cs_val(cs_val), .ss_val(ss_val), .ds_val(ds_val),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .out_valid(out_valid), .is_reg(is_reg), .rm_reg_idx(rm_reg_idx),
        .fld_reg_idx(fld_reg_idx), .disp_bytes(disp_bytes), .seg_sel(seg_sel),
        .ea_offset(ea_offset), .phys_addr(phys_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // present one operand for one cycle; return at the falling edge after capture
    task automatic apply(input logic [7:0] m, input logic w, input logic [7:0] lo,
                         input logic [7:0] hi, input logic oe, input logic [1:0] os);
        @(negedge clk);
        modrm = m; wide = w; disp_lo = lo; disp_hi = hi; ovr_en = oe; ovr_sel = os;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [19:0] phys_of(input logic [15:0] seg, input logic [15:0] ofs);
        return ({4'h0, seg} << 4) + {4'h0, ofs};
    endfunction

    function automatic logic [15:0] pair_sum(input logic [2:0] s);
        case (s)
            3'd0: return bx_val + si_val;
            3'd1: return bx_val + di_val;
            3'd2: return bp_val + si_val;
            3'd3: return bp_val + di_val;
            3'd4: return si_val;
            3'd5: return di_val;
            3'd6: return bp_val;
            default: return bx_val;
        endcase
    endfunction

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", {31'b0, out_valid}, 32'd0);
        chk("R1 offset in reset", {16'b0, ea_offset}, 32'd0);
        chk("R1 phys in reset", {12'b0, phys_addr}, 32'd0);
        chk("R1 seg/disp in reset", {28'b0, seg_sel, disp_bytes}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {27'b0, out_valid, fld_reg_idx}, 32'd0);
    endtask

    task automatic t_register;
        apply(8'hC3, 1'b1, 8'h55, 8'h66, 1'b0, 2'b00);
        chk("R2 valid one cycle later", {31'b0, out_valid}, 32'd1);
        chk("R3 is_reg word", {31'b0, is_reg}, 32'd1);
        chk("R3 rm idx word", {28'b0, rm_reg_idx}, 32'hB);
        chk("R3 offset/phys/disp zero", {10'b0, disp_bytes, phys_addr}, 32'd0);
        chk("R13 field idx word", {28'b0, fld_reg_idx}, 32'h8);
        @(negedge clk);
        chk("R2 valid single cycle", {31'b0, out_valid}, 32'd0);
        apply(8'hE0, 1'b0, 8'h00, 8'h00, 1'b0, 2'b00);
        chk("R3 rm idx byte", {28'b0, rm_reg_idx}, 32'h0);
        chk("R13 field idx byte", {28'b0, fld_reg_idx}, 32'h4);
    endtask

    task automatic t_mode0_sweep;
        for (int s = 0; s < 8; s++) begin
            if (s == 6) continue;
            apply({5'b00_010, 3'(s)}, 1'b1, 8'hEE, 8'hDD, 1'b0, 2'b00);
            chk($sformatf("R8 R4 sel %0d offset", s), {16'b0, ea_offset}, {16'b0, pair_sum(3'(s))});
            chk($sformatf("R4 sel %0d no disp", s), {30'b0, disp_bytes}, 32'd0);
            chk($sformatf("R11 sel %0d seg", s), {30'b0, seg_sel}, (s == 2 || s == 3) ? 32'd2 : 32'd3);
            chk($sformatf("R10 sel %0d phys", s), {12'b0, phys_addr},
                {12'b0, phys_of((s == 2 || s == 3) ? ss_val : ds_val, pair_sum(3'(s)))});
            chk("R2 valid", {31'b0, out_valid}, 32'd1);
        end
    endtask

    task automatic t_direct;
        apply(8'h06, 1'b0, 8'h20, 8'h01, 1'b0, 2'b00);
        chk("R5 direct offset", {16'b0, ea_offset}, 32'h0120);
        chk("R5 direct disp bytes", {30'b0, disp_bytes}, 32'd2);
        chk("R5 direct seg DS", {30'b0, seg_sel}, 32'd3);
        chk("R10 direct phys", {12'b0, phys_addr}, 32'h12460);
    endtask

    task automatic t_disp8;
        apply(8'h41, 1'b0, 8'h03, 8'h77, 1'b0, 2'b00);
        chk("R6 BX+DI+3", {16'b0, ea_offset}, 32'h1007);
        chk("R6 one disp byte", {30'b0, disp_bytes}, 32'd1);
        apply(8'h41, 1'b0, 8'hFE, 8'h77, 1'b0, 2'b00);
        chk("R6 negative disp8", {16'b0, ea_offset}, 32'h1002);
        apply(8'h46, 1'b1, 8'h10, 8'h00, 1'b0, 2'b00);
        chk("R7 BP+disp8 offset", {16'b0, ea_offset}, 32'h2010);
        chk("R11 BP form uses SS", {30'b0, seg_sel}, 32'd2);
        chk("R10 SS phys", {12'b0, phys_addr}, 32'h52010);
    endtask

    task automatic t_disp16_wrap;
        apply(8'h87, 1'b1, 8'h00, 8'hF0, 1'b0, 2'b00);
        chk("R9 BX+F000 wraps", {16'b0, ea_offset}, 32'h0000);
        chk("R7 two disp bytes", {30'b0, disp_bytes}, 32'd2);
        chk("R10 phys after wrap", {12'b0, phys_addr}, 32'h12340);
        apply(8'hB6, 1'b1, 8'h34, 8'h12, 1'b0, 2'b00);
        chk("R7 BP+disp16", {16'b0, ea_offset}, 32'h3234);
    endtask

    task automatic t_override;
        apply(8'h84, 1'b1, 8'hF0, 8'hFF, 1'b1, 2'b01);
        chk("R9 SI+FFF0 wraps", {16'b0, ea_offset}, 32'h0020);
        chk("R12 CS selected", {30'b0, seg_sel}, 32'd1);
        chk("R10 phys wraps at 1MB", {12'b0, phys_addr}, 32'h00010);
        apply(8'h46, 1'b1, 8'h00, 8'h00, 1'b1, 2'b00);
        chk("R12 ES over SS", {30'b0, seg_sel}, 32'd0);
        chk("R12 ES phys", {12'b0, phys_addr}, 32'hA2000);
        apply(8'h06, 1'b0, 8'h00, 8'h01, 1'b1, 2'b10);
        chk("R12 SS over DS direct", {12'b0, phys_addr}, 32'h50100);
    endtask

    task automatic t_hold;
        logic [15:0] o_prev;
        logic [19:0] p_prev;
        apply(8'h00, 1'b1, 8'h00, 8'h00, 1'b0, 2'b00);
        o_prev = ea_offset;
        p_prev = phys_addr;
        modrm = 8'h87; disp_lo = 8'h11; disp_hi = 8'h22; bx_val = 16'h4444;
        repeat (3) @(negedge clk);
        chk("R14 valid low while idle", {31'b0, out_valid}, 32'd0);
        chk("R14 offset held", {16'b0, ea_offset}, {16'b0, o_prev});
        chk("R14 phys held", {12'b0, phys_addr}, {12'b0, p_prev});
        bx_val = 16'h1000;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset;
        t_register;
        t_mode0_sweep;
        t_direct;
        t_disp8;
        t_disp16_wrap;
        t_override;
        t_hold;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule